// File: doc/BRIEF.md
# Byte ALU with Condition-Code Register

This block is the arithmetic and logic stage of a small accumulator-style processor core. Each cycle it takes a 5-bit operation select and two 8-bit operands. It works out an 8-bit result combinationally, in the same cycle. The current flags come from an internal condition-code byte. The block computes the next value of that byte, and the byte is written at the clock edge whenever the operation is marked valid.

The operation set covers binary arithmetic with and without carry, subtract and compare, the bitwise operations and a bit test, an operand move, and single-operand operations on operand A. The single-operand group holds negate, complement, increment, decrement, test and clear, the three shifts, the two rotates through carry, and decimal adjust. Each operation has its own flag rules, and those rules are the main point of the block. One extra operation loads the six defined flag bits from operand B. Surrounding logic uses it to restore a saved flag state.

Top module: `alu8_cc`

## Requirements
- R1: After reset `ccOut` is 0x00. Flag bits are C at bit 0, V at bit 1, Z at bit 2, N at bit 3, I at bit 4 and H at bit 5. `ccOut` takes the new flags at a rising clock edge only when `opValid` is high, and holds otherwise.
- R2: Add (code 0x00) and add-with-carry (0x01, carry-in = C) return A+B(+C) mod 256. C = carry out of bit 7, H = carry out of bit 3 including the carry-in, V = signed overflow, N = result bit 7, Z = result is zero.
- R3: Subtract (0x02), subtract-with-borrow (0x03, borrow-in = C) and compare (0x04) form A-B(-C). C is set on an unsigned borrow, V on signed overflow, and N and Z follow the difference. Compare returns A unchanged. H is unchanged.
- R4: AND (0x05), bit test (0x06), OR (0x07), XOR (0x08) and move (0x09, result = B) clear V, set N and Z from the value formed, and leave C and H unchanged. Bit test returns A unchanged.
- R5: Negate (0x0A) returns 0-A. V is set only when the result is 0x80, C is set whenever the result is nonzero, and N and Z follow the result.
- R6: Complement (0x0B) returns the bitwise inverse of A, forces V to 0 and C to 1, and sets N and Z from the result.
- R7: Increment (0x0C) and decrement (0x0D) return A+1 and A-1 mod 256. V is set only for operand 0x7F (increment) or 0x80 (decrement). N and Z follow the result, and C is unchanged.
- R8: Test (0x0E) returns A, clears V, sets N and Z from A and keeps C. Clear (0x0F) returns 0, sets Z, and clears N, V and C.
- R9: Logical shift right (0x10) moves a 0 into bit 7 and forces N to 0. Arithmetic shift right (0x11) keeps bit 7. Both put old bit 0 into C. Shift left (0x12) fills bit 0 with 0 and puts old bit 7 into C. All three set Z from the result, non-forced N from result bit 7, and leave V unchanged.
- R10: Rotate right (0x13) puts the old C into bit 7 and old bit 0 into C. Rotate left (0x14) puts the old C into bit 0 and old bit 7 into C. N and Z follow the result and V is unchanged.
- R11: Decimal adjust (0x15) adds 0x60 when C is set, or the high nibble exceeds 9, or the high nibble exceeds 8 while the low nibble exceeds 9. It adds 0x06 when H is set or the low nibble exceeds 9, and adds 0x66 when both apply. C becomes old C OR the carry of that addition, and it is never cleared here. N and Z follow the result, and V and H are unchanged.
- R12: Flag load (0x16) returns A and copies B bits 5:0 into flag bits 5:0. Bits 7:6 are unchanged.
- R13: Every operation except flag load leaves I and bits 7:6 unchanged. Codes 0x17 to 0x1F return A and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | High to write the computed flags at this edge |
| opCode | input | 5 | Operation select |
| operandA | input | 8 | Accumulator operand, also the single-operand input |
| operandB | input | 8 | Second operand, or the flag value for flag load |
| result | output | 8 | Combinational result for the current inputs |
| ccOut | output | 8 | Registered condition-code byte |

## Verification
The assertions sample at rising edges. They assume that `opCode` and both operands are settled before each edge, so that the decoded control and the next flag byte describe the operation actually being applied. The stimulus changes every input at the falling edge. It reads `result` during the low phase and reads `ccOut` just after the following rising edge. The bench sets the incoming flags of each case through the flag-load operation, so every carry and half-carry preset is reached through the ports.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int CC_W   = 8;
  localparam int OP_W   = 5;

  localparam int FL_C = 0;
  localparam int FL_V = 1;
  localparam int FL_Z = 2;
  localparam int FL_N = 3;
  localparam int FL_I = 4;
  localparam int FL_H = 5;
  localparam int FL_DEF = 6;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'h00, OP_ADC = 5'h01, OP_SUB = 5'h02, OP_SBC = 5'h03,
    OP_CMP  = 5'h04, OP_AND = 5'h05, OP_BIT = 5'h06, OP_OR  = 5'h07,
    OP_XOR  = 5'h08, OP_MOV = 5'h09, OP_NEG = 5'h0A, OP_COM = 5'h0B,
    OP_INC  = 5'h0C, OP_DEC = 5'h0D, OP_TST = 5'h0E, OP_CLR = 5'h0F,
    OP_LSR  = 5'h10, OP_ASR = 5'h11, OP_ASL = 5'h12, OP_ROR = 5'h13,
    OP_ROL  = 5'h14, OP_DAA = 5'h15, OP_CCLD = 5'h16
  } opcode_e;

  typedef enum logic [2:0] {
    U_PASS, U_ADD, U_SUB, U_LOGIC, U_UNARY, U_SHIFT, U_DAA, U_CCLD
  } unit_e;

  typedef enum logic [1:0] { LF_AND, LF_OR, LF_XOR, LF_MOV } logic_fn_e;

  typedef enum logic [2:0] {
    SF_NEG = 3'd0, SF_COM = 3'd1, SF_INC = 3'd2, SF_DEC = 3'd3,
    SF_TST = 3'd4, SF_CLR = 3'd5
  } unary_fn_e;

  typedef enum logic [2:0] {
    SH_LSR = 3'd0, SH_ASR = 3'd1, SH_ASL = 3'd2, SH_ROR = 3'd3, SH_ROL = 3'd4
  } shift_fn_e;

  typedef struct packed {
    unit_e      unit;
    logic       withCarry;
    logic       keepA;
    logic_fn_e  logicFn;
    logic [2:0] subFn;
  } ctrl_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opCode,
  output ctrl_t           ctl
);

  always_comb begin
    ctl = '{unit: U_PASS, withCarry: 1'b0, keepA: 1'b0,
            logicFn: LF_AND, subFn: 3'd0};
    case (opCode)
      OP_ADD:  ctl.unit = U_ADD;
      OP_ADC:  begin ctl.unit = U_ADD; ctl.withCarry = 1'b1; end
      OP_SUB:  ctl.unit = U_SUB;
      OP_SBC:  begin ctl.unit = U_SUB; ctl.withCarry = 1'b1; end
      OP_CMP:  begin ctl.unit = U_SUB; ctl.keepA = 1'b1; end
      OP_AND:  begin ctl.unit = U_LOGIC; ctl.logicFn = LF_AND; end
      OP_BIT:  begin ctl.unit = U_LOGIC; ctl.logicFn = LF_AND; ctl.keepA = 1'b1; end
      OP_OR:   begin ctl.unit = U_LOGIC; ctl.logicFn = LF_OR; end
      OP_XOR:  begin ctl.unit = U_LOGIC; ctl.logicFn = LF_XOR; end
      OP_MOV:  begin ctl.unit = U_LOGIC; ctl.logicFn = LF_MOV; end
      OP_NEG:  begin ctl.unit = U_UNARY; ctl.subFn = SF_NEG; end
      OP_COM:  begin ctl.unit = U_UNARY; ctl.subFn = SF_COM; end
      OP_INC:  begin ctl.unit = U_UNARY; ctl.subFn = SF_INC; end
      OP_DEC:  begin ctl.unit = U_UNARY; ctl.subFn = SF_DEC; end
      OP_TST:  begin ctl.unit = U_UNARY; ctl.subFn = SF_TST; end
      OP_CLR:  begin ctl.unit = U_UNARY; ctl.subFn = SF_CLR; end
      OP_LSR:  begin ctl.unit = U_SHIFT; ctl.subFn = SH_LSR; end
      OP_ASR:  begin ctl.unit = U_SHIFT; ctl.subFn = SH_ASR; end
      OP_ASL:  begin ctl.unit = U_SHIFT; ctl.subFn = SH_ASL; end
      OP_ROR:  begin ctl.unit = U_SHIFT; ctl.subFn = SH_ROR; end
      OP_ROL:  begin ctl.unit = U_SHIFT; ctl.subFn = SH_ROL; end
      OP_DAA:  ctl.unit = U_DAA;
      OP_CCLD: ctl.unit = U_CCLD;
      default: ctl.unit = U_PASS;
    endcase
  end

  // R3 R4
  keep_a_scope_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.keepA |-> (ctl.unit == U_SUB || ctl.unit == U_LOGIC));

  // R13
  unused_code_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode > OP_CCLD) |-> (ctl.unit == U_PASS));

endmodule

// File: rtl/alu8_dp.sv
module alu8_dp
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [CC_W-1:0]   flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [CC_W-1:0]   flagsNext
);

  localparam logic [DATA_W-1:0] SIGN_MIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] SIGN_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [NIB_W-1:0]  BCD_NINE = NIB_W'(9);
  localparam logic [NIB_W-1:0]  BCD_EIGHT = NIB_W'(8);
  localparam logic [NIB_W-1:0]  BCD_FIX = NIB_W'(6);

  logic              cin;
  logic [DATA_W:0]   wide;
  logic [NIB_W:0]    nib;
  logic [DATA_W-1:0] rr;
  logic [NIB_W-1:0]  hiNib;
  logic [NIB_W-1:0]  loNib;
  logic              upFix;
  logic              loFix;
  logic [DATA_W-1:0] daaAdd;

  always_comb begin
    flagsNext = flagsIn;
    result    = opA;
    cin       = ctl.withCarry & flagsIn[FL_C];
    wide      = '0;
    nib       = '0;
    rr        = opA;
    hiNib     = opA[DATA_W-1:NIB_W];
    loNib     = opA[NIB_W-1:0];
    upFix     = 1'b0;
    loFix     = 1'b0;
    daaAdd    = '0;

    case (ctl.unit)
      U_ADD: begin
        wide = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, cin};
        nib  = {1'b0, opA[NIB_W-1:0]} + {1'b0, opB[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
        rr   = wide[DATA_W-1:0];
        result = rr;
        flagsNext[FL_H] = nib[NIB_W];
        flagsNext[FL_C] = wide[DATA_W];
        flagsNext[FL_V] = (opA[DATA_W-1] == opB[DATA_W-1]) && (rr[DATA_W-1] != opA[DATA_W-1]);
        flagsNext[FL_N] = rr[DATA_W-1];
        flagsNext[FL_Z] = (rr == '0);
      end

      U_SUB: begin
        wide = {1'b0, opA} - {1'b0, opB} - {{DATA_W{1'b0}}, cin};
        rr   = wide[DATA_W-1:0];
        result = ctl.keepA ? opA : rr;
        flagsNext[FL_C] = wide[DATA_W];
        flagsNext[FL_V] = (opA[DATA_W-1] != opB[DATA_W-1]) && (rr[DATA_W-1] != opA[DATA_W-1]);
        flagsNext[FL_N] = rr[DATA_W-1];
        flagsNext[FL_Z] = (rr == '0);
      end

      U_LOGIC: begin
        case (ctl.logicFn)
          LF_AND:  rr = opA & opB;
          LF_OR:   rr = opA | opB;
          LF_XOR:  rr = opA ^ opB;
          default: rr = opB;
        endcase
        result = ctl.keepA ? opA : rr;
        flagsNext[FL_V] = 1'b0;
        flagsNext[FL_N] = rr[DATA_W-1];
        flagsNext[FL_Z] = (rr == '0);
      end

      U_UNARY: begin
        case (ctl.subFn)
          SF_NEG: begin
            rr = '0 - opA;
            flagsNext[FL_V] = (rr == SIGN_MIN);
            flagsNext[FL_C] = (rr != '0);
          end
          SF_COM: begin
            rr = ~opA;
            flagsNext[FL_V] = 1'b0;
            flagsNext[FL_C] = 1'b1;
          end
          SF_INC: begin
            rr = opA + DATA_W'(1);
            flagsNext[FL_V] = (opA == SIGN_MAX);
          end
          SF_DEC: begin
            rr = opA - DATA_W'(1);
            flagsNext[FL_V] = (opA == SIGN_MIN);
          end
          SF_CLR: begin
            rr = '0;
            flagsNext[FL_V] = 1'b0;
            flagsNext[FL_C] = 1'b0;
          end
          default: begin
            rr = opA;
            flagsNext[FL_V] = 1'b0;
          end
        endcase
        result = rr;
        flagsNext[FL_N] = rr[DATA_W-1];
        flagsNext[FL_Z] = (rr == '0);
      end

      U_SHIFT: begin
        case (ctl.subFn)
          SH_LSR: begin
            rr = {1'b0, opA[DATA_W-1:1]};
            flagsNext[FL_C] = opA[0];
          end
          SH_ASR: begin
            rr = {opA[DATA_W-1], opA[DATA_W-1:1]};
            flagsNext[FL_C] = opA[0];
          end
          SH_ASL: begin
            rr = {opA[DATA_W-2:0], 1'b0};
            flagsNext[FL_C] = opA[DATA_W-1];
          end
          SH_ROR: begin
            rr = {flagsIn[FL_C], opA[DATA_W-1:1]};
            flagsNext[FL_C] = opA[0];
          end
          default: begin
            rr = {opA[DATA_W-2:0], flagsIn[FL_C]};
            flagsNext[FL_C] = opA[DATA_W-1];
          end
        endcase
        result = rr;
        flagsNext[FL_N] = rr[DATA_W-1];
        flagsNext[FL_Z] = (rr == '0);
      end

      U_DAA: begin
        upFix  = flagsIn[FL_C] || (hiNib > BCD_NINE) ||
                 ((hiNib > BCD_EIGHT) && (loNib > BCD_NINE));
        loFix  = flagsIn[FL_H] || (loNib > BCD_NINE);
        daaAdd = {(upFix ? BCD_FIX : {NIB_W{1'b0}}), (loFix ? BCD_FIX : {NIB_W{1'b0}})};
        wide   = {1'b0, opA} + {1'b0, daaAdd};
        rr     = wide[DATA_W-1:0];
        result = rr;
        flagsNext[FL_C] = flagsIn[FL_C] | wide[DATA_W];
        flagsNext[FL_N] = rr[DATA_W-1];
        flagsNext[FL_Z] = (rr == '0);
      end

      U_CCLD: begin
        flagsNext[FL_DEF-1:0] = opB[FL_DEF-1:0];
      end

      default: begin
        flagsNext = flagsIn;
      end
    endcase
  end

  // R4
  logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.unit == U_LOGIC) |-> (!flagsNext[FL_V] && flagsNext[FL_C] == flagsIn[FL_C]));

  // R7
  inc_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.unit == U_UNARY && ctl.subFn == SF_INC && opA == SIGN_MAX)
      |-> (flagsNext[FL_V] && result == SIGN_MIN));

  // R9 R10
  shift_keeps_v_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.unit == U_SHIFT) |-> (flagsNext[FL_V] == flagsIn[FL_V]));

  // R11
  daa_sticky_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.unit == U_DAA && flagsIn[FL_C]) |-> flagsNext[FL_C]);

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.unit == U_UNARY && ctl.subFn == SF_CLR) |-> (result == '0 && flagsNext[FL_Z]));

endmodule

// File: rtl/alu8_ccreg.sv
module alu8_ccreg
  import alu8_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            we,
  input  logic            loadAll,
  input  logic [CC_W-1:0] d,
  output logic [CC_W-1:0] q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else if (we) q <= d;
  end

  // R1
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !we |=> $stable(q));

  // R13
  ibit_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (we && !loadAll) |=> (q[FL_I] == $past(q[FL_I]) && q[CC_W-1:FL_DEF] == $past(q[CC_W-1:FL_DEF])));

endmodule

// File: rtl/alu8_cc.sv
module alu8_cc
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  output logic [DATA_W-1:0] result,
  output logic [CC_W-1:0]   ccOut
);

  ctrl_t           ctl;
  logic [CC_W-1:0] flagsNext;

  alu8_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .opCode (opCode),
    .ctl    (ctl)
  );

  alu8_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .opA       (operandA),
    .opB       (operandB),
    .flagsIn   (ccOut),
    .result    (result),
    .flagsNext (flagsNext)
  );

  alu8_ccreg ccreg_i (
    .clk     (clk),
    .rstN    (rstN),
    .we      (opValid),
    .loadAll (ctl.unit == U_CCLD),
    .d       (flagsNext),
    .q       (ccOut)
  );

endmodule

// File: tb/alu8_cc_tb.sv
module alu8_cc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opCode = 5'h1F;
  logic [7:0] operandA = 8'h00;
  logic [7:0] operandB = 8'h00;
  logic [7:0] result;
  logic [7:0] ccOut;

  int checks = 0;
  int failures = 0;
  logic [7:0] ccExp = 8'h00;
  bit done = 1'b0;

  alu8_cc dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .operandA(operandA), .operandB(operandB), .result(result), .ccOut(ccOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string reqOf(input logic [4:0] op);
    if (op <= 5'h01) return "R2";
    if (op <= 5'h04) return "R3";
    if (op <= 5'h09) return "R4";
    if (op == 5'h0A) return "R5";
    if (op == 5'h0B) return "R6";
    if (op <= 5'h0D) return "R7";
    if (op <= 5'h0F) return "R8";
    if (op <= 5'h12) return "R9";
    if (op <= 5'h14) return "R10";
    if (op == 5'h15) return "R11";
    if (op == 5'h16) return "R12";
    return "R13";
  endfunction

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // Reference model written from the requirement text.
  task automatic model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] cc, output logic [7:0] r, output logic [7:0] n);
    int ai, bi, ci, t, s, hi, lo;
    logic [7:0] v;
    bit setNz;
    ai = int'(a); bi = int'(b); ci = int'(cc[0]);
    n = cc; r = a; v = a; setNz = 1'b1;
    case (op)
      5'h00, 5'h01: begin
        if (op == 5'h00) ci = 0;
        t = ai + bi + ci; v = t[7:0]; r = v;
        n[0] = (t > 255);
        n[5] = ((ai % 16) + (bi % 16) + ci) > 15;
        s = sgn(ai) + sgn(bi) + ci;
        n[1] = (s > 127) || (s < -128);
      end
      5'h02, 5'h03, 5'h04: begin
        if (op != 5'h03) ci = 0;
        t = ai - bi - ci; v = t[7:0];
        r = (op == 5'h04) ? a : v;
        n[0] = (t < 0);
        s = sgn(ai) - sgn(bi) - ci;
        n[1] = (s > 127) || (s < -128);
      end
      5'h05, 5'h06: begin v = a & b; r = (op == 5'h06) ? a : v; n[1] = 1'b0; end
      5'h07: begin v = a | b; r = v; n[1] = 1'b0; end
      5'h08: begin v = a ^ b; r = v; n[1] = 1'b0; end
      5'h09: begin v = b; r = v; n[1] = 1'b0; end
      5'h0A: begin t = (256 - ai) % 256; v = t[7:0]; r = v; n[1] = (t == 128); n[0] = (t != 0); end
      5'h0B: begin t = 255 - ai; v = t[7:0]; r = v; n[1] = 1'b0; n[0] = 1'b1; end
      5'h0C: begin t = (ai + 1) % 256; v = t[7:0]; r = v; n[1] = (ai == 127); end
      5'h0D: begin t = (ai + 255) % 256; v = t[7:0]; r = v; n[1] = (ai == 128); end
      5'h0E: begin v = a; r = a; n[1] = 1'b0; end
      5'h0F: begin v = 8'h00; r = v; n[1] = 1'b0; n[0] = 1'b0; end
      5'h10: begin t = ai / 2; v = t[7:0]; r = v; n[0] = ai[0]; end
      5'h11: begin t = ai / 2 + ((ai >= 128) ? 128 : 0); v = t[7:0]; r = v; n[0] = ai[0]; end
      5'h12: begin t = (ai * 2) % 256; v = t[7:0]; r = v; n[0] = (ai >= 128); end
      5'h13: begin t = ai / 2 + ci * 128; v = t[7:0]; r = v; n[0] = ai[0]; end
      5'h14: begin t = (ai * 2) % 256 + ci; v = t[7:0]; r = v; n[0] = (ai >= 128); end
      5'h15: begin
        hi = ai / 16; lo = ai % 16;
        t = ai;
        if ((ci == 1) || (hi > 9) || ((hi > 8) && (lo > 9))) t = t + 96;
        if (cc[5] || (lo > 9)) t = t + 6;
        v = t[7:0]; r = v;
        n[0] = (ci == 1) || (t > 255);
      end
      5'h16: begin n = {cc[7:6], b[5:0]}; setNz = 1'b0; end
      default: setNz = 1'b0;
    endcase
    if (setNz) begin
      n[3] = v[7];
      n[2] = (v == 8'h00);
      if (op == 5'h10) n[3] = 1'b0;
    end
  endtask

  task automatic check8(input string req, input string what, input logic [7:0] act,
                        input logic [7:0] exp, input logic [4:0] op,
                        input logic [7:0] a, input logic [7:0] b);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s op=%02h a=%02h b=%02h actual=%02h expected=%02h",
               req, what, op, a, b, act, exp);
    end
  endtask

  task automatic runOp(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input bit doCheck);
    logic [7:0] rExp, nExp;
    model(op, a, b, ccExp, rExp, nExp);
    @(negedge clk);
    opValid = 1'b1; opCode = op; operandA = a; operandB = b;
    #1;
    if (doCheck) check8(reqOf(op), "result", result, rExp, op, a, b);
    @(posedge clk);
    #1;
    ccExp = nExp;
    if (doCheck) check8(reqOf(op), "flags", ccOut, ccExp, op, a, b);
  endtask

  task automatic presetFlags(input logic [7:0] f);
    runOp(5'h16, 8'h00, f, 1'b0);
  endtask

  initial begin
    for (int cyc = 0; cyc < WATCHDOG_CYCLES; cyc++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [7:0] B_VALS [8] = '{8'h00, 8'h01, 8'h0F, 8'h7F, 8'h80, 8'h81, 8'hF0, 8'hFF};
  localparam logic [7:0] U_PRE  [4] = '{8'h00, 8'h3F, 8'h21, 8'h1E};

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset value
    check8("R1", "reset flags", ccOut, 8'h00, 5'h00, 8'h00, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    // R12: flag load, bits 7:6 of operand ignored
    runOp(5'h16, 8'h5A, 8'hFF, 1'b1);
    runOp(5'h16, 8'hA5, 8'h12, 1'b1);

    // R1: hold when opValid is low
    @(negedge clk);
    opValid = 1'b0; opCode = 5'h0F; operandA = 8'h77;
    @(posedge clk); #1;
    check8("R1", "hold flags", ccOut, ccExp, 5'h0F, 8'h77, 8'h00);
    @(posedge clk); #1;
    check8("R1", "hold flags 2nd", ccOut, ccExp, 5'h0F, 8'h77, 8'h00);

    // R2 R3 R4: binary sweep
    for (int op = 0; op <= 9; op++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi < 8; bi++)
          for (int c = 0; c < 2; c++) begin
            presetFlags(c != 0 ? 8'h37 : 8'h2A);
            runOp(5'(op), 8'(a), B_VALS[bi], 1'b1);
          end

    // R5..R11: single-operand sweep with varied incoming flags
    for (int op = 10; op <= 21; op++)
      for (int a = 0; a < 256; a++)
        for (int p = 0; p < 4; p++) begin
          presetFlags(U_PRE[p]);
          runOp(5'(op), 8'(a), 8'hC3, 1'b1);
        end

    // R11: decimal adjust after a decimal add, 0x19 + 0x28 -> 0x47
    presetFlags(8'h00);
    runOp(5'h00, 8'h19, 8'h28, 1'b1);
    runOp(5'h15, 8'h41, 8'h00, 1'b1);
    check8("R11", "bcd sum", result, 8'h47, 5'h15, 8'h41, 8'h00);

    // R13: unused codes pass A and keep flags
    for (int op = 23; op <= 31; op++)
      for (int k = 0; k < 4; k++) begin
        presetFlags(U_PRE[k]);
        runOp(5'(op), 8'(k * 67 + 5), 8'hFF, 1'b1);
      end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule